// File: doc/BRIEF.md
# Masked Vector High-Element Interleave Unit

This unit is a single-stage execution slice for a 512-bit SIMD datapath. It views each source vector as 128-bit lanes of two 64-bit elements. In every lane it builds a result from the upper element of the first source followed by the upper element of the second source. Element contents are opaque bit patterns, and no arithmetic is performed on them.

Around that shuffle the unit applies several options. A 64-bit broadcast can replace every element of the second source. A per-element mask selects interleaved data, and masked-off elements are either merged with the old destination or zeroed. A length select picks 2, 4 or 8 active elements. An encoding class sets how the bits above the active length are treated: the legacy class keeps the old destination there, and both extended classes clear them.

Operands enter over a valid/ready stream and the result leaves over a second one. An operand set is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The result is held unchanged, with `out_valid` high, until a cycle in which `out_ready` is high.

Top module: `hi_interleave_unit`

## Requirements
- R1: For every processed 128-bit lane L, result element 2L equals first-source element 2L+1, and result element 2L+1 equals (possibly broadcast) second-source element 2L+1.
- R2: `vlen_sel` codes are 00 = 2 elements, 01 = 4 elements, 1x = 8 elements. For the masked extended class (`enc_cls` = 1x), every result bit at or above the active length is zero.
- R3: In the masked extended class with `bcast_en` = 1, every second-source element is replaced by `src_b[63:0]` before the interleave.
- R4: In the masked extended class with `mask_en` = 1 and `zero_mode` = 0, an active element whose `elem_mask` bit is 0 keeps its `dst_old` value. An active element whose mask bit is 1 takes the interleaved value. With `mask_en` = 0, every active element takes the interleaved value.
- R5: In the masked extended class with `mask_en` = 1 and `zero_mode` = 1, an active element whose mask bit is 0 is zero.
- R6: The plain extended class (`enc_cls` = 01) processes 2 elements for `vlen_sel` = 00 and 4 elements for any other code. All elements above that length are zero. `elem_mask`, `mask_en`, `zero_mode` and `bcast_en` have no effect in this class.
- R7: The legacy class (`enc_cls` = 00) processes exactly 2 elements whatever `vlen_sel` is. Result bits [511:128] equal `dst_old[511:128]`. Mask, zero-mode and broadcast inputs have no effect in this class.
- R8: Mask bits for elements at or above the active length have no effect on the result.
- R9: An accepted operand set produces `out_valid` with its result on the next clock edge. While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_valid` hold. `in_ready` = !`out_valid` || `out_ready`. `out_valid` falls after a handshake when no new set is accepted.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can accept an operand set |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value for merging and preserving |
| elem_mask | input | 8 | Per-element write mask |
| vlen_sel | input | 2 | Active length: 00 = 128, 01 = 256, 1x = 512 bits |
| bcast_en | input | 1 | Broadcast the low element of src_b |
| mask_en | input | 1 | Apply elem_mask |
| zero_mode | input | 1 | 1 = zero masked-off elements, 0 = merge |
| enc_cls | input | 2 | 00 legacy, 01 plain extended, 1x masked extended |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Result vector |

## Verification
The hardest condition to reach from the ports is an output register stalled by `out_ready` = 0 while a new operand set is already waiting. In that state the result must hold, and the waiting set must enter in the same cycle the old result drains. The bench drives `out_ready` at random, mostly high, while a driver offers operand sets back to back, so stalls and same-cycle drain-and-refill occur many times. Random sources, masks, lengths, classes and broadcast flags are compared against an independent lane-by-lane model. Directed items pin mask bits beyond the active length and set ignored controls in the legacy and plain classes.

// File: rtl/hiu_pkg.sv
package hiu_pkg;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512X = 2'b11
  } vlen_e;

  typedef enum logic [1:0] {
    CLS_LEGACY  = 2'b00,
    CLS_PLAIN   = 2'b01,
    CLS_MASKED  = 2'b10,
    CLS_MASKEDX = 2'b11
  } enc_cls_e;

  typedef struct packed {
    logic keep_upper;
    logic use_mask;
    logic use_bcast;
    logic zero_fill;
  } ctl_t;

endpackage

// File: rtl/hiu_bcast.sv
module hiu_bcast #(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 8,
  localparam int VEC_W = ELEM_W * N_ELEM
) (
  input  logic [VEC_W-1:0] src_in,
  input  logic             bcast,
  output logic [VEC_W-1:0] src_out
);

  for (genvar e = 0; e < N_ELEM; e++) begin : g_el
    assign src_out[e*ELEM_W +: ELEM_W] =
      bcast ? src_in[ELEM_W-1:0] : src_in[e*ELEM_W +: ELEM_W];
  end

endmodule

// File: rtl/hiu_interleave.sv
module hiu_interleave #(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 8,
  localparam int VEC_W  = ELEM_W * N_ELEM,
  localparam int N_LANE = N_ELEM / 2
) (
  input  logic [VEC_W-1:0] first,
  input  logic [VEC_W-1:0] second,
  output logic [VEC_W-1:0] ilv
);

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    localparam int LO = 2 * l;
    localparam int HI = 2 * l + 1;
    assign ilv[LO*ELEM_W +: ELEM_W] = first[HI*ELEM_W +: ELEM_W];
    assign ilv[HI*ELEM_W +: ELEM_W] = second[HI*ELEM_W +: ELEM_W];
  end

endmodule

// File: rtl/hiu_mask_merge.sv
module hiu_mask_merge
  import hiu_pkg::*;
#(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 8,
  localparam int VEC_W = ELEM_W * N_ELEM,
  localparam int CNT_W = $clog2(N_ELEM + 1)
) (
  input  logic [VEC_W-1:0]  ilv,
  input  logic [VEC_W-1:0]  old,
  input  logic [N_ELEM-1:0] mask,
  input  logic [CNT_W-1:0]  n_act,
  input  ctl_t              ctl,
  output logic [VEC_W-1:0]  res
);

  for (genvar e = 0; e < N_ELEM; e++) begin : g_el
    localparam logic [CNT_W-1:0] IDX = CNT_W'(e);
    logic              in_len;
    logic              take;
    logic [ELEM_W-1:0] off_val;
    logic [ELEM_W-1:0] tail_val;

    assign in_len   = IDX < n_act;
    assign take     = !ctl.use_mask || mask[e];
    assign off_val  = ctl.zero_fill ? '0 : old[e*ELEM_W +: ELEM_W];
    assign tail_val = ctl.keep_upper ? old[e*ELEM_W +: ELEM_W] : '0;

    assign res[e*ELEM_W +: ELEM_W] =
      in_len ? (take ? ilv[e*ELEM_W +: ELEM_W] : off_val) : tail_val;
  end

endmodule

// File: rtl/hi_interleave_unit.sv
module hi_interleave_unit
  import hiu_pkg::*;
#(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 8,
  localparam int VEC_W = ELEM_W * N_ELEM,
  localparam int CNT_W = $clog2(N_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [VEC_W-1:0]  dst_old,
  input  logic [N_ELEM-1:0] elem_mask,
  input  logic [1:0]        vlen_sel,
  input  logic              bcast_en,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [1:0]        enc_cls,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);

  localparam logic [CNT_W-1:0] CNT_NARROW = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_MID    = CNT_W'(4);
  localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(N_ELEM);

  vlen_e            vl;
  enc_cls_e         cls;
  ctl_t             ctl;
  logic [CNT_W-1:0] n_act;
  logic             accept;
  logic [VEC_W-1:0] src_b_eff;
  logic [VEC_W-1:0] ilv;
  logic [VEC_W-1:0] res;

  assign vl  = vlen_e'(vlen_sel);
  assign cls = enc_cls_e'(enc_cls);

  always_comb begin
    ctl   = '0;
    n_act = CNT_NARROW;
    unique case (cls)
      CLS_LEGACY: begin
        ctl.keep_upper = 1'b1;
        n_act          = CNT_NARROW;
      end
      CLS_PLAIN: begin
        n_act = (vl == VL_128) ? CNT_NARROW : CNT_MID;
      end
      CLS_MASKED, CLS_MASKEDX: begin
        ctl.use_mask  = mask_en;
        ctl.use_bcast = bcast_en;
        ctl.zero_fill = zero_mode;
        unique case (vl)
          VL_128:          n_act = CNT_NARROW;
          VL_256:          n_act = CNT_MID;
          VL_512, VL_512X: n_act = CNT_FULL;
        endcase
      end
    endcase
  end

  hiu_bcast #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_bcast (
    .src_in  (src_b),
    .bcast   (ctl.use_bcast),
    .src_out (src_b_eff)
  );

  hiu_interleave #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_ilv (
    .first  (src_a),
    .second (src_b_eff),
    .ilv    (ilv)
  );

  hiu_mask_merge #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_merge (
    .ilv   (ilv),
    .old   (dst_old),
    .mask  (elem_mask),
    .n_act (n_act),
    .ctl   (ctl),
    .res   (res)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hiu_checker.sv
module hiu_checker #(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 8,
  localparam int VEC_W  = ELEM_W * N_ELEM,
  localparam int LANE_W = 2 * ELEM_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VEC_W-1:0]  src_a,
  input logic [VEC_W-1:0]  dst_old,
  input logic [N_ELEM-1:0] elem_mask,
  input logic [1:0]        vlen_sel,
  input logic              mask_en,
  input logic [1:0]        enc_cls,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_data
);

  logic acc;
  assign acc = in_valid && in_ready;

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_result_next_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_drain_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!acc && !(out_valid && !out_ready)) |=> !out_valid);

  p_legacy_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && enc_cls == 2'b00) |=>
      out_data[VEC_W-1:LANE_W] == $past(dst_old[VEC_W-1:LANE_W]));

  p_narrow_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && enc_cls != 2'b00 && vlen_sel == 2'b00) |=>
      out_data[VEC_W-1:LANE_W] == '0);

  p_lane0_low_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && (!enc_cls[1] || !mask_en || elem_mask[0])) |=>
      out_data[ELEM_W-1:0] == $past(src_a[LANE_W-1:ELEM_W]));

endmodule

bind hi_interleave_unit hiu_checker #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_hiu_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_a     (src_a),
  .dst_old   (dst_old),
  .elem_mask (elem_mask),
  .vlen_sel  (vlen_sel),
  .mask_en   (mask_en),
  .enc_cls   (enc_cls),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_hi_interleave_unit.sv
`timescale 1ns/1ps
module tb_hi_interleave_unit;

  localparam int EW = 64;
  localparam int NE = 8;
  localparam int VW = EW * NE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [VW-1:0] dst_old = '0;
  logic [NE-1:0] elem_mask = '0;
  logic [1:0]    vlen_sel = '0;
  logic          bcast_en = 1'b0;
  logic          mask_en = 1'b0;
  logic          zero_mode = 1'b0;
  logic [1:0]    enc_cls = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit force_ready = 1'b1;
  bit mon_on = 1'b0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  hi_interleave_unit #(.ELEM_W(EW), .N_ELEM(NE)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .elem_mask(elem_mask),
    .vlen_sel(vlen_sel), .bcast_en(bcast_en), .mask_en(mask_en),
    .zero_mode(zero_mode), .enc_cls(enc_cls), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [VW-1:0] act, input logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Lane-by-lane model written from the requirements
  function automatic logic [VW-1:0] model(
      input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old,
      input logic [NE-1:0] m, input logic [1:0] vl, input logic [1:0] cls,
      input logic bc, input logic me, input logic zm);
    logic [VW-1:0] r;
    logic [VW-1:0] bb;
    logic [EW-1:0] val;
    int n;
    bit msk;
    msk = cls[1];
    bb = b;
    if (msk && bc)
      for (int e = 0; e < NE; e++) bb[e*EW +: EW] = b[EW-1:0];
    if (cls == 2'b00) n = 2;
    else if (!msk) n = (vl == 2'b00) ? 2 : 4;
    else n = (vl == 2'b00) ? 2 : ((vl == 2'b01) ? 4 : 8);
    r = (cls == 2'b00) ? old : '0;
    for (int l = 0; l < n / 2; l++) begin
      for (int k = 0; k < 2; k++) begin
        int e;
        e = 2 * l + k;
        val = (k == 0) ? a[(2*l+1)*EW +: EW] : bb[(2*l+1)*EW +: EW];
        if (msk && me && !m[e]) val = zm ? '0 : old[e*EW +: EW];
        r[e*EW +: EW] = val;
      end
    end
    return r;
  endfunction

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] old, input logic [NE-1:0] m,
                      input logic [1:0] vl, input logic [1:0] cls,
                      input logic bc, input logic me, input logic zm,
                      input string tag);
    bit done;
    @(negedge clk); #2;
    src_a = a; src_b = b; dst_old = old; elem_mask = m; vlen_sel = vl;
    enc_cls = cls; bcast_en = bc; mask_en = me; zero_mode = zm;
    in_valid = 1'b1;
    done = 1'b0;
    while (!done) begin
      #3;
      if (in_ready) done = 1'b1;
      else begin
        @(negedge clk); #2;
      end
    end
    exp_q.push_back(model(a, b, old, m, vl, cls, bc, me, zm));
    tag_q.push_back(tag);
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    logic [VW-1:0] held;
    bit was_stall;
    was_stall = 1'b0;
    held = '0;
    wait (mon_on);
    forever begin
      @(negedge clk); #1;
      out_ready = force_ready ? 1'b1 : (($urandom % 4) != 0);
      #5;
      if (was_stall)
        chk(out_valid && out_data == held, "R9 stall hold", out_data, held);
      was_stall = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", out_data, '0);
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, o;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R10 reset state", out_data, '0);
    rst = 1'b0;
    mon_on = 1'b1;

    a = rand_vec(); b = rand_vec(); o = rand_vec();
    send(a, b, o, 8'hFF, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, "R1 full interleave");
    chk(out_valid == 1'b1, "R9 latency", {{(VW-1){1'b0}}, out_valid}, 1);
    send(a, b, o, 8'h00, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, "R2 length 256 zero tail");
    send(a, b, o, 8'hFF, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, "R2 length 128 zero tail");
    send(a, b, o, 8'hFF, 2'b10, 2'b10, 1'b1, 1'b0, 1'b0, "R3 broadcast");
    send(a, b, o, 8'hA5, 2'b11, 2'b10, 1'b0, 1'b1, 1'b0, "R4 merge mask");
    send(a, b, o, 8'h3C, 2'b10, 2'b10, 1'b1, 1'b1, 1'b1, "R5 zero mask");
    send(a, b, o, 8'h00, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, "R6 plain 512 code as 256");
    send(a, b, o, 8'h00, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0, "R6 plain 128");
    send(a, b, o, 8'h00, 2'b10, 2'b00, 1'b1, 1'b1, 1'b1, "R7 legacy keeps upper");
    send(a, b, o, 8'hFC, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0, "R8 mask beyond length 128");
    send(a, b, o, 8'h0F, 2'b01, 2'b10, 1'b0, 1'b1, 1'b1, "R8 mask beyond length 256");

    force_ready = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] vl, cls;
      logic bc, me, zm;
      string tg;
      vl = 2'($urandom); cls = 2'($urandom);
      bc = 1'($urandom); me = 1'($urandom); zm = 1'($urandom);
      if (cls == 2'b00) tg = "R7 random legacy";
      else if (!cls[1]) tg = "R6 random plain";
      else if (me && zm) tg = "R5 random zero";
      else if (me) tg = "R4 random merge";
      else if (bc) tg = "R3 random broadcast";
      else tg = "R2 random length";
      send(rand_vec(), rand_vec(), rand_vec(), 8'($urandom), vl, cls, bc, me, zm, tg);
    end

    force_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #8;
    chk(out_valid == 1'b0, "R9 idle drains", {{(VW-1){1'b0}}, out_valid}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule